// File: doc/BRIEF.md
# Multiplexed Bus Demux Capture

This block watches a target's shared address/data bus and turns it into a stream of address-plus-data records for a trace buffer. It samples on the target's own clock. Two qualified events drive it: an address event, which is a rising clock edge with the address strobe asserted, and a data event, which is a rising clock edge with the data strobe asserted. Both events sample the same bus pins.

An address event stores the bus value as a pending address. The next data event pairs the stored address with the bus value as data and emits one record with a one-cycle valid pulse. Each strobe has its own static polarity bit. A split-mode input selects how events are treated. With split mode off, the bus is treated as non-multiplexed and every qualified sample is a plain data record. With split mode on, a cycle in which both strobes are asserted cannot be told apart as address or data, so that sample is also taken as plain data.

Status is carried with each record. An orphan flag marks a data event that had no address before it. A sticky overrun bit records that a pending address was overwritten.

Top module: `mbd_capture_top`

## Requirements
- R1: A rising clock edge with the address strobe asserted and the data strobe not asserted (split mode on) stores the bus value as the pending address and emits no record.
- R2: A rising clock edge with the data strobe asserted and the address strobe not asserted (split mode on) makes rec_valid high for exactly the next cycle. rec_data is then the bus value sampled at that edge and rec_addr is the pending address. The pending address is then consumed.
- R3: Strobe polarity bit cfg_as_pol / cfg_ds_pol = 0 means the strobe is asserted when low; 1 means it is asserted when high. Each strobe has its own bit.
- R4: A data event with no pending address gives a record with rec_orphan=1 and rec_addr=0. Otherwise rec_orphan=0.
- R5: An address event while an address is already pending overwrites it and sets overrun, which stays 1 until reset.
- R6: With split_en=0, every edge with either strobe asserted gives a record with rec_plain=1, rec_orphan=0, rec_addr=0 and rec_data=bus. The pending address is not changed.
- R7: With split_en=1 and both strobes asserted at the same edge, a plain record is emitted (rec_plain=1, rec_addr=0). The pending address is kept.
- R8: After synchronous reset: rec_valid=0, overrun=0 and no address is pending.
- R9: rec_valid is 0 in every cycle that does not follow a data or plain event. The record fields hold their last values while rec_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Target-supplied sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_as_pol | input | 1 | Address strobe polarity (0 = asserted low) |
| cfg_ds_pol | input | 1 | Data strobe polarity (0 = asserted low) |
| split_en | input | 1 | 1 = multiplexed (address/data) mode, 0 = plain data mode |
| as_n | input | 1 | Address strobe pin |
| ds_n | input | 1 | Data strobe pin |
| bus | input | BUS_W | Shared address/data bus |
| rec_valid | output | 1 | One-cycle record strobe |
| rec_addr | output | BUS_W | Paired address of the record |
| rec_data | output | BUS_W | Data of the record |
| rec_orphan | output | 1 | Data event with no preceding address |
| rec_plain | output | 1 | Record from a non-split sample |
| overrun | output | 1 | Sticky: a pending address was overwritten |

## Verification
The hardest case to reach is the interaction of pending-address state with the rest of the inputs. This covers an overwrite followed by an orphan-free record, a both-strobes edge that arrives while an address is pending, and these same sequences under inverted strobe polarity. The bench sweeps all eight combinations of the two polarity bits and split mode. For each one it runs a long event sequence computed from the step index, so every ordering of address, data, both and idle edges occurs back to back. A model in the bench predicts each record from those requirement rules.

// File: rtl/mbd_pkg.sv
package mbd_pkg;

    typedef enum logic [1:0] {
        EV_NONE  = 2'd0,
        EV_ADDR  = 2'd1,
        EV_DATA  = 2'd2,
        EV_PLAIN = 2'd3
    } evt_kind_e;

    // Map the two qualified strobes to one event kind for this edge.
    function automatic evt_kind_e classify(input logic a_hit, input logic d_hit,
                                           input logic split);
        evt_kind_e k;
        if (!split)             k = (a_hit || d_hit) ? EV_PLAIN : EV_NONE;
        else if (a_hit && d_hit) k = EV_PLAIN;
        else if (a_hit)          k = EV_ADDR;
        else if (d_hit)          k = EV_DATA;
        else                     k = EV_NONE;
        return k;
    endfunction

endpackage

// File: rtl/mbd_strobe_qual.sv
module mbd_strobe_qual #(
    parameter int N_STROBE = 2
) (
    input  logic [N_STROBE-1:0] pin,
    input  logic [N_STROBE-1:0] pol,
    output logic [N_STROBE-1:0] hit
);
    for (genvar g = 0; g < N_STROBE; g++) begin : g_q
        // pol=0: asserted when pin is low; pol=1: asserted when high
        assign hit[g] = pol[g] ? pin[g] : ~pin[g];
    end
endmodule

// File: rtl/mbd_addr_hold.sv
module mbd_addr_hold
    import mbd_pkg::*;
#(
    parameter int BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  evt_kind_e        kind,
    input  logic [BUS_W-1:0] bus,
    output logic             pend,
    output logic [BUS_W-1:0] paddr,
    output logic             ovr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pend  <= 1'b0;
            paddr <= '0;
            ovr   <= 1'b0;
        end else begin
            case (kind)
                EV_ADDR: begin
                    paddr <= bus;
                    pend  <= 1'b1;
                    if (pend) ovr <= 1'b1;
                end
                EV_DATA: pend <= 1'b0;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/mbd_rec_build.sv
module mbd_rec_build
    import mbd_pkg::*;
#(
    parameter int BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  evt_kind_e        kind,
    input  logic [BUS_W-1:0] bus,
    input  logic             pend,
    input  logic [BUS_W-1:0] paddr,
    output logic             valid,
    output logic [BUS_W-1:0] addr,
    output logic [BUS_W-1:0] data,
    output logic             orphan,
    output logic             plain
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid  <= 1'b0;
            addr   <= '0;
            data   <= '0;
            orphan <= 1'b0;
            plain  <= 1'b0;
        end else begin
            valid <= (kind == EV_DATA) || (kind == EV_PLAIN);
            if (kind == EV_DATA) begin
                addr   <= pend ? paddr : '0;
                data   <= bus;
                orphan <= ~pend;
                plain  <= 1'b0;
            end else if (kind == EV_PLAIN) begin
                addr   <= '0;
                data   <= bus;
                orphan <= 1'b0;
                plain  <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/mbd_capture_top.sv
module mbd_capture_top
    import mbd_pkg::*;
#(
    parameter int BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_as_pol,
    input  logic             cfg_ds_pol,
    input  logic             split_en,
    input  logic             as_n,
    input  logic             ds_n,
    input  logic [BUS_W-1:0] bus,
    output logic             rec_valid,
    output logic [BUS_W-1:0] rec_addr,
    output logic [BUS_W-1:0] rec_data,
    output logic             rec_orphan,
    output logic             rec_plain,
    output logic             overrun
);
    localparam int N_STROBE = 2;
    localparam int IDX_A = 0;
    localparam int IDX_D = 1;

    logic [N_STROBE-1:0] hit;
    evt_kind_e           kind;
    logic                pend;
    logic [BUS_W-1:0]    paddr;

    mbd_strobe_qual #(.N_STROBE(N_STROBE)) u_qual (
        .pin ({ds_n, as_n}),
        .pol ({cfg_ds_pol, cfg_as_pol}),
        .hit (hit)
    );

    assign kind = classify(hit[IDX_A], hit[IDX_D], split_en);

    mbd_addr_hold #(.BUS_W(BUS_W)) u_hold (
        .clk   (clk),
        .rst   (rst),
        .kind  (kind),
        .bus   (bus),
        .pend  (pend),
        .paddr (paddr),
        .ovr   (overrun)
    );

    mbd_rec_build #(.BUS_W(BUS_W)) u_rec (
        .clk    (clk),
        .rst    (rst),
        .kind   (kind),
        .bus    (bus),
        .pend   (pend),
        .paddr  (paddr),
        .valid  (rec_valid),
        .addr   (rec_addr),
        .data   (rec_data),
        .orphan (rec_orphan),
        .plain  (rec_plain)
    );
endmodule

// File: rtl/mbd_capture_chk.sv
module mbd_capture_chk #(
    parameter int BUS_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_as_pol,
    input logic             cfg_ds_pol,
    input logic             split_en,
    input logic             as_n,
    input logic             ds_n,
    input logic [BUS_W-1:0] bus,
    input logic             rec_valid,
    input logic [BUS_W-1:0] rec_addr,
    input logic             rec_orphan,
    input logic             rec_plain,
    input logic             overrun
);
    logic a_on, d_on;
    assign a_on = (as_n == cfg_as_pol);
    assign d_on = (ds_n == cfg_ds_pol);

    AST_DATA_GIVES_RECORD: assert property (@(posedge clk) disable iff (rst)
        d_on |=> rec_valid); // R2
    AST_RECORD_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        rec_valid |-> $past(d_on || (a_on && !split_en))); // R9
    AST_ADDR_ONLY_SILENT: assert property (@(posedge clk) disable iff (rst)
        (split_en && a_on && !d_on) |=> !rec_valid); // R1
    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun); // R5
    AST_PLAIN_NO_ADDR: assert property (@(posedge clk) disable iff (rst)
        (rec_valid && rec_plain) |-> (rec_addr == '0 && !rec_orphan)); // R6
    AST_ORPHAN_NO_ADDR: assert property (@(posedge clk) disable iff (rst)
        (rec_valid && rec_orphan) |-> (rec_addr == '0)); // R4
endmodule

bind mbd_capture_top mbd_capture_chk #(.BUS_W(BUS_W)) u_chk (
    .clk(clk), .rst(rst), .cfg_as_pol(cfg_as_pol), .cfg_ds_pol(cfg_ds_pol),
    .split_en(split_en), .as_n(as_n), .ds_n(ds_n), .bus(bus),
    .rec_valid(rec_valid), .rec_addr(rec_addr), .rec_orphan(rec_orphan),
    .rec_plain(rec_plain), .overrun(overrun)
);

// File: tb/sim_mbd_capture_top.sv
module sim_mbd_capture_top;
    localparam int BUS_W  = 8;
    localparam int PERIOD = 10;
    localparam int STEPS  = 300;

    logic clk = 1'b0;
    logic rst, cfg_as_pol, cfg_ds_pol, split_en, as_n, ds_n;
    logic [BUS_W-1:0] bus;
    logic rec_valid, rec_orphan, rec_plain, overrun;
    logic [BUS_W-1:0] rec_addr, rec_data;

    int n_chk = 0;
    int n_bad = 0;

    always #(PERIOD/2) clk = ~clk;

    mbd_capture_top #(.BUS_W(BUS_W)) u0 (
        .clk(clk), .rst(rst), .cfg_as_pol(cfg_as_pol), .cfg_ds_pol(cfg_ds_pol),
        .split_en(split_en), .as_n(as_n), .ds_n(ds_n), .bus(bus),
        .rec_valid(rec_valid), .rec_addr(rec_addr), .rec_data(rec_data),
        .rec_orphan(rec_orphan), .rec_plain(rec_plain), .overrun(overrun)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // model state
    logic m_pend, m_ovr;
    logic [BUS_W-1:0] m_paddr, l_addr, l_data;
    logic l_orph, l_plain;

    initial begin
        #(PERIOD*200000);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; cfg_as_pol = 0; cfg_ds_pol = 0; split_en = 1;
        as_n = 1; ds_n = 1; bus = '0;
        for (int cfg = 0; cfg < 8; cfg++) begin
            @(negedge clk);
            rst = 1'b1;
            cfg_as_pol = cfg[0]; cfg_ds_pol = cfg[1]; split_en = ~cfg[2];
            as_n = ~cfg_as_pol; ds_n = ~cfg_ds_pol;
            @(negedge clk);
            rst = 1'b0;
            check("R8 valid", rec_valid, 0);
            check("R8 overrun", overrun, 0);
            m_pend = 0; m_ovr = 0; m_paddr = '0;
            l_addr = '0; l_data = '0; l_orph = 0; l_plain = 0;
            for (int i = 0; i < STEPS; i++) begin
                logic ea, ed, ev;
                string tag;
                int e;
                e = (i * 5 + i / 7 + i / 31 + cfg) % 4;
                ea = e[0]; ed = e[1];
                bus = BUS_W'(i * 37 + cfg * 11 + 3);
                // R3: asserted level equals polarity bit
                as_n = ea ? cfg_as_pol : ~cfg_as_pol;
                ds_n = ed ? cfg_ds_pol : ~cfg_ds_pol;
                ev = 0; tag = "R9 idle";
                if (!split_en) begin
                    if (ea || ed) begin
                        ev = 1; l_addr = '0; l_data = bus; l_orph = 0; l_plain = 1;
                        tag = "R6 plain";
                    end
                end else if (ea && ed) begin
                    ev = 1; l_addr = '0; l_data = bus; l_orph = 0; l_plain = 1;
                    tag = "R7 both";
                end else if (ea) begin
                    if (m_pend) m_ovr = 1;
                    m_pend = 1; m_paddr = bus;
                    tag = m_ovr ? "R5 addr" : "R1 addr";
                end else if (ed) begin
                    ev = 1; l_data = bus; l_plain = 0;
                    l_orph = ~m_pend; l_addr = m_pend ? m_paddr : '0;
                    tag = m_pend ? "R2 data" : "R4 orphan";
                    m_pend = 0;
                end
                @(posedge clk);
                #1;
                check({tag, " valid R3"}, rec_valid, ev);
                check({tag, " addr"}, rec_addr, l_addr);
                check({tag, " data"}, rec_data, l_data);
                check({tag, " orphan"}, rec_orphan, l_orph);
                check({tag, " plain"}, rec_plain, l_plain);
                check("R5 overrun", overrun, m_ovr);
                @(negedge clk);
            end
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule